// File: doc/BRIEF.md
# PWM Channel with Boundary-Aligned Update

This block is one pulse-width-modulation channel. A free-running period counter advances once per prescaled clock. The prescaler divides the system clock by a power of two. Each period opens at the inactive output level. The duty value counts how many prescaled clocks stay inactive before the output switches to the active level for the rest of the period. A polarity setting selects which logic level counts as active.

Software can retune a running channel through a single staging register. The staged value goes into either the duty register or the period register, as a target select in the mode settings decides. It takes effect only at the next period boundary, so no pulse is ever cut short or glitched. The prescaler select and the polarity are frozen while the channel runs. Direct loads of the period and duty registers are accepted only while the channel is stopped. A one-clock period-start strobe marks the first clock of every period that follows a counter wrap.

Top module: `pwm_chan`

## Requirements
- R1: While `enable` is low, `pwm_out` sits at the inactive level, `period_start` is low and the counter is held at zero. After `enable` rises, the first period starts from count zero. For a PRD of P with a divide of 1, the first `period_start` appears P+1 clocks after the clock in which `enable` is first seen high.
- R2: A period lasts PRD × 2^N system clocks, where N is `cfg_presc`. Any select above MAX_SHIFT (default 10) behaves as MAX_SHIFT.
- R3: Within a period, the first DTY prescaled clocks are inactive and the remaining PRD − DTY prescaled clocks are active. The first clock of a period is inactive whenever DTY > 0.
- R4: If DTY ≥ PRD, the whole period is inactive. If DTY = 0, the whole period is active.
- R5: With `cfg_invert` = 0 the active level is 1 and the inactive level is 0. With `cfg_invert` = 1 both levels are swapped, and this also applies while the channel is disabled.
- R6: A staged write with the target select at 0 (`cfg_upd_period` = 0) replaces DTY at the next period boundary. The period in progress is not altered.
- R7: A staged write with the target select at 1 replaces PRD at the next period boundary.
- R8: A mode write while the channel runs leaves the prescaler select and the polarity unchanged, but it does update the target select. While the channel is stopped, every mode field is loaded.
- R9: Direct writes to PRD or DTY are ignored while the channel runs and accepted while it is stopped.
- R10: `period_start` is high for exactly the first system clock of each period that follows a wrap, and the counter reads zero in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel run control |
| mode_wr | input | 1 | Mode write strobe |
| cfg_presc | input | PRE_W | Prescaler select N (divide by 2^N) |
| cfg_invert | input | 1 | Polarity: 1 swaps active and inactive levels |
| cfg_upd_period | input | 1 | Staging target: 0 = duty, 1 = period |
| prd_wr | input | 1 | Direct period write strobe (stopped only) |
| dty_wr | input | 1 | Direct duty write strobe (stopped only) |
| upd_wr | input | 1 | Staging register write strobe |
| wdata | input | CNT_W | Data for the period, duty and staging writes |
| pwm_out | output | 1 | PWM waveform |
| period_start | output | 1 | One-clock strobe at the first clock of a new period |

## Verification
The bench builds the channel with its defaults: 16-bit period and duty, a 4-bit prescaler select and MAX_SHIFT of 10. Because the select is four bits wide, the bench can drive values above MAX_SHIFT, so the clamp at a divide of 1024 is exercised. Short periods (1 to 12 counts) keep every divided period within a few thousand clocks. That puts one-count periods, duty equal to or above the period, and back-to-back wraps within reach of full-period measurements.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    typedef enum logic {
        UPD_TO_DUTY   = 1'b0,
        UPD_TO_PERIOD = 1'b1
    } upd_target_e;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int SEL_W     = 4,
    parameter int MAX_SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_state_t;

    pre_state_t       q, d;
    logic [DIV_W-1:0] mask;
    int               shift;

    always_comb begin
        shift = (int'(sel) > MAX_SHIFT) ? MAX_SHIFT : int'(sel);
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < shift);
        end
        tick = run && ((q.div & mask) == mask);
        d = q;
        if (!run || tick) begin
            d.div = '0;
        end else begin
            d.div = q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_DIV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((q.div & ~mask) == '0)); // R2

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t q, d;
    logic       last;

    always_comb begin
        last = (prd <= CNT_W'(1)) || (q.cnt >= prd - CNT_W'(1));
        wrap = run && tick && last;
        d = q;
        if (!run) begin
            d.cnt = '0;
        end else if (tick) begin
            d.cnt = last ? '0 : q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt = q.cnt;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((q.cnt < prd) || (q.cnt == '0))); // R2

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_open,
    input  logic             prd_wr,
    input  logic             dty_wr,
    input  logic             upd_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wrap,
    input  upd_target_e      target,
    output logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] dty
);
    typedef struct packed {
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] dty;
        logic [CNT_W-1:0] stg;
        logic             pend;
    } shadow_state_t;

    shadow_state_t q, d;

    always_comb begin
        d = q;
        if (cfg_open && prd_wr) begin
            d.prd = wdata;
        end
        if (cfg_open && dty_wr) begin
            d.dty = wdata;
        end
        if (wrap && q.pend) begin
            if (target == UPD_TO_PERIOD) begin
                d.prd = q.stg;
            end else begin
                d.dty = q.stg;
            end
            d.pend = 1'b0;
        end
        if (upd_wr) begin
            d.stg  = wdata;
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign prd = q.prd;
    assign dty = q.dty;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !cfg_open) |=> ($stable(q.prd) && $stable(q.dty))); // R6

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRE_W     = 4,
    parameter int MAX_SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_wr,
    input  logic [PRE_W-1:0] cfg_presc,
    input  logic             cfg_invert,
    input  logic             cfg_upd_period,
    input  logic             prd_wr,
    input  logic             dty_wr,
    input  logic             upd_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic             pwm_out,
    output logic             period_start
);
    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             inv;
        upd_target_e      tgt;
        logic             en;
        logic             ps;
    } chan_state_t;

    chan_state_t      q, d;
    logic             run;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] prd;
    logic [CNT_W-1:0] dty;

    assign run = q.en && enable;

    pwm_prescaler #(
        .SEL_W     (PRE_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (q.presc),
        .tick  (tick)
    );

    pwm_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .prd   (prd),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    pwm_shadow #(
        .CNT_W (CNT_W)
    ) u_shd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_open (!q.en),
        .prd_wr   (prd_wr),
        .dty_wr   (dty_wr),
        .upd_wr   (upd_wr),
        .wdata    (wdata),
        .wrap     (wrap),
        .target   (q.tgt),
        .prd      (prd),
        .dty      (dty)
    );

    always_comb begin
        d    = q;
        d.en = enable;
        d.ps = wrap;
        if (mode_wr) begin
            d.tgt = cfg_upd_period ? UPD_TO_PERIOD : UPD_TO_DUTY;
            if (!q.en) begin
                d.presc = cfg_presc;
                d.inv   = cfg_invert;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{presc: '0, inv: 1'b0, tgt: UPD_TO_DUTY, en: 1'b0, ps: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pwm_out      = (q.en && (cnt >= dty)) ? ~q.inv : q.inv;
    assign period_start = q.ps;

    AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((pwm_out == q.inv) && !period_start)); // R1

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && $past(q.en)) |-> ($stable(q.presc) && $stable(q.inv))); // R8

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (cnt == '0)); // R10

endmodule

// File: tb/pwm_chan_test.sv
module pwm_chan_test;
    localparam int CW = 16;
    localparam int PW = 4;

    typedef struct packed {
        logic [3:0]  n;
        logic        pol;
        logic [15:0] prd;
        logic [15:0] dty;
        logic [31:0] len;
        logic [31:0] act;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  1'b0, 16'd10, 16'd4, 32'd10,   32'd6},
        '{4'd0,  1'b1, 16'd10, 16'd4, 32'd10,   32'd6},
        '{4'd2,  1'b0, 16'd5,  16'd2, 32'd20,   32'd12},
        '{4'd0,  1'b0, 16'd8,  16'd0, 32'd8,    32'd8},
        '{4'd0,  1'b0, 16'd6,  16'd6, 32'd6,    32'd0},
        '{4'd0,  1'b1, 16'd6,  16'd9, 32'd6,    32'd0},
        '{4'd1,  1'b1, 16'd1,  16'd0, 32'd2,    32'd2},
        '{4'd15, 1'b0, 16'd3,  16'd1, 32'd3072, 32'd2048},
        '{4'd10, 1'b1, 16'd2,  16'd1, 32'd2048, 32'd1024}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          mode_wr = 1'b0;
    logic [PW-1:0] cfg_presc = '0;
    logic          cfg_invert = 1'b0;
    logic          cfg_upd_period = 1'b0;
    logic          prd_wr = 1'b0;
    logic          dty_wr = 1'b0;
    logic          upd_wr = 1'b0;
    logic [CW-1:0] wdata = '0;
    logic          pwm_out;
    logic          period_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pwm_chan uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .mode_wr        (mode_wr),
        .cfg_presc      (cfg_presc),
        .cfg_invert     (cfg_invert),
        .cfg_upd_period (cfg_upd_period),
        .prd_wr         (prd_wr),
        .dty_wr         (dty_wr),
        .upd_wr         (upd_wr),
        .wdata          (wdata),
        .pwm_out        (pwm_out),
        .period_start   (period_start)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic wr_mode(input logic [PW-1:0] n, input logic inv, input logic tgt);
        @(posedge clk); #1;
        mode_wr = 1'b1; cfg_presc = n; cfg_invert = inv; cfg_upd_period = tgt;
        @(posedge clk); #1;
        mode_wr = 1'b0;
    endtask

    task automatic wr_reg(input int which, input logic [CW-1:0] v);
        @(posedge clk); #1;
        wdata = v;
        prd_wr = (which == 0);
        dty_wr = (which == 1);
        upd_wr = (which == 2);
        @(posedge clk); #1;
        prd_wr = 1'b0; dty_wr = 1'b0; upd_wr = 1'b0;
    endtask

    task automatic cfg(input logic [3:0] n, input logic pol, input logic [CW-1:0] p, input logic [CW-1:0] du);
        @(posedge clk); #1;
        enable = 1'b0;
        @(posedge clk);
        @(posedge clk);
        wr_mode(n, pol, 1'b0);
        wr_reg(0, p);
        wr_reg(1, du);
        @(posedge clk); #1;
        enable = 1'b1;
    endtask

    // Measures one full period delimited by period_start strobes.
    task automatic measure(input bit at_start, input logic lvl, output int len, output int act,
                           output logic first_out, output logic second_ps);
        if (!at_start) begin
            @(negedge clk);
            while (!period_start) @(negedge clk);
        end
        len = 0; act = 0; first_out = pwm_out; second_ps = 1'b0;
        do begin
            if (pwm_out == lvl) act++;
            len++;
            @(negedge clk);
            if (len == 1) second_ps = period_start;
        end while (!period_start);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int len, act, k;
        logic fo, sp;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset pwm_out", pwm_out, 0);
        chk("R1", "reset period_start", period_start, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Table of configurations, one full period measured each.
        for (int i = 0; i < NV; i++) begin
            cfg(VEC[i].n, VEC[i].pol, VEC[i].prd, VEC[i].dty);
            measure(1'b0, ~VEC[i].pol, len, act, fo, sp);
            chk("R2", $sformatf("vec %0d period length", i), len, VEC[i].len);
            chk("R3 R4 R5", $sformatf("vec %0d active clocks", i), act, VEC[i].act);
            if (VEC[i].dty != 0)
                chk("R3", $sformatf("vec %0d first clock inactive", i), fo, VEC[i].pol);
            if (VEC[i].len > 1)
                chk("R10", $sformatf("vec %0d strobe one clock", i), sp, 0);
        end

        // R1: restart from zero after enable.
        cfg(4'd0, 1'b0, 16'd10, 16'd4);
        @(negedge clk);
        chk("R1", "output inactive before first count", pwm_out, 0);
        k = 0;
        while (!period_start) begin k++; @(negedge clk); end
        chk("R1", "clocks to first period_start", k, 11);

        // R6: staged duty waits for the boundary.
        measure(1'b1, 1'b1, len, act, fo, sp);
        wr_reg(2, 16'd7);
        act = 0;
        @(negedge clk);
        while (!period_start) begin
            if (pwm_out) act++;
            @(negedge clk);
        end
        chk("R6", "running period keeps old duty", act, 6);
        measure(1'b1, 1'b1, len, act, fo, sp);
        chk("R6", "next period uses staged duty", act, 3);
        chk("R6", "period length unchanged", len, 10);

        // R7 and R8: target select accepted while running, staged period.
        wr_mode(4'd0, 1'b0, 1'b1);
        wr_reg(2, 16'd12);
        measure(1'b0, 1'b1, len, act, fo, sp);
        chk("R7", "staged period length", len, 12);
        chk("R7", "active clocks after period change", act, 5);

        // R8: prescaler and polarity ignored while running.
        wr_mode(4'd3, 1'b1, 1'b1);
        measure(1'b0, 1'b1, len, act, fo, sp);
        chk("R8", "prescaler frozen while running", len, 12);
        chk("R8", "polarity frozen while running", act, 5);

        // R9: direct duty write ignored while running.
        wr_reg(1, 16'd0);
        measure(1'b0, 1'b1, len, act, fo, sp);
        chk("R9", "direct duty write ignored", act, 5);

        // R1 / R5: disabled level for both polarities.
        @(posedge clk); #1;
        enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "disabled output", pwm_out, 0);
        chk("R1", "disabled strobe", period_start, 0);
        wr_mode(4'd0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R5", "disabled inverted output", pwm_out, 1);

        // R9: direct write accepted while stopped.
        wr_mode(4'd0, 1'b0, 1'b0);
        wr_reg(1, 16'd0);
        @(posedge clk); #1;
        enable = 1'b1;
        measure(1'b0, 1'b1, len, act, fo, sp);
        chk("R9", "direct duty write while stopped", act, 12);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule